// File: doc/BRIEF.md
# Prioritized Bus Release Arbiter

This block decides who drives a shared external memory bus. Three internal users can own it: a memory refresh engine, a DMA controller and the CPU. A device outside the chip can also ask for the bus through an active-low request pin. When that device asks, the arbiter lets the running bus cycle finish. It then drives the strobes to their idle high level for one cycle, turns off the address, data and strobe drivers, and only after that pulls the active-low acknowledge pin low.

The external device outranks every internal user, including a DMA burst that is in progress. If a refresh falls due while the bus is lent out, the arbiter raises acknowledge again to ask for the bus back. It keeps its drivers off until the device takes its request high, and then hands the bus to refresh. Ownership among the internal users changes only at bus-cycle boundaries. The CPU owns the bus whenever nobody else asks.

Top module: `bus_release_arb`

## Requirements
- R1: While reset is applied, and right after it, the CPU grant is 1, the other grants are 0, acknowledge is high, all three output enables are 1 and the strobe-park signal is 0.
- R2: Internal ownership follows the fixed order refresh over DMA over CPU. With no internal request, the CPU is granted.
- R3: At most one grant is high at any time. No grant is high while acknowledge is low or while a handover is in progress.
- R4: A release follows a fixed order. In the first cycle, strobe-park is 1 with the enables still 1 and all grants 0. In the next cycle, all enables are 0 with acknowledge still high. In the cycle after that, acknowledge goes low.
- R5: Whenever acknowledge is low, the address, data and strobe output enables are all 0.
- R6: An external request (input low) takes the bus at the next cycle boundary even while the DMA request stays high.
- R7: Grants change, and a release starts, only in the cycle after cycle_done is high. The request pin passes through a two-flop synchronizer, so a low request is first acted on at the third clock edge after it is applied.
- R8: A refresh request while the bus is lent out raises acknowledge at the next edge. The enables stay 0 until the synchronized request is seen high, and the bus then returns with the refresh grant.
- R9: When the external device drops its request while the bus is lent out, the bus returns with the grant chosen by the internal priority order.
- R10: After a refresh that reclaimed the bus ends at a cycle boundary, a request that is still low triggers the full park, float and acknowledge sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | External bus request, active low, asynchronous to clk |
| refresh_req | input | 1 | Refresh engine needs the bus |
| dma_req | input | 1 | DMA controller needs the bus |
| cycle_done | input | 1 | The current bus cycle ends in this clock |
| ext_ack_n | output | 1 | Bus released acknowledge, active low |
| gnt_refresh | output | 1 | Bus granted to refresh |
| gnt_dma | output | 1 | Bus granted to DMA |
| gnt_cpu | output | 1 | Bus granted to CPU |
| addr_oe | output | 1 | Address pin output enable |
| data_oe | output | 1 | Data pin output enable |
| strobe_oe | output | 1 | Strobe pin output enable |
| strobe_park | output | 1 | Force strobes to their inactive high level |

## Verification
A handover state machine that skips a step shows up at the pins within one clock. Acknowledge would fall while an enable is still 1, or the enables would drop without a park cycle before them. A wrong owner register shows as a grant that moves without a cycle boundary, or that breaks the refresh, DMA, CPU order, on the edge right after the boundary. A synchronizer with the wrong depth shifts the start of the release by one edge. A reclaim that does not wait would turn the enables back on while the bench still holds the request low.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    localparam int NUM_INT = 3;
    localparam int IDX_REF = 0;
    localparam int IDX_DMA = 1;
    localparam int IDX_CPU = 2;

    typedef enum logic [2:0] {
        ST_OWN,
        ST_PARK,
        ST_FLOAT,
        ST_LENT,
        ST_RECLAIM
    } arb_state_e;

    typedef struct packed {
        arb_state_e           state;
        logic [NUM_INT-1:0]   owner;
    } arb_regs_t;

endpackage

// File: rtl/breq_sync.sv
module breq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] onehot
);

    logic found;

    // lowest index has highest priority
    always_comb begin
        onehot = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                onehot[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb
    import bus_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req_n,
    input  logic refresh_req,
    input  logic dma_req,
    input  logic cycle_done,
    output logic ext_ack_n,
    output logic gnt_refresh,
    output logic gnt_dma,
    output logic gnt_cpu,
    output logic addr_oe,
    output logic data_oe,
    output logic strobe_oe,
    output logic strobe_park
);

    localparam logic [NUM_INT-1:0] CPU_ONLY = NUM_INT'(1) << IDX_CPU;

    logic               req_n_sync;
    logic               ext_want;
    logic [NUM_INT-1:0] int_req;
    logic [NUM_INT-1:0] int_pick;
    arb_regs_t          regs_d, regs_q;
    logic               drive_on;
    logic [2:0]         gnt_vec;

    breq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ext_req_n),
        .q_out (req_n_sync)
    );

    assign ext_want = !req_n_sync;

    always_comb begin
        int_req          = '0;
        int_req[IDX_REF] = refresh_req;
        int_req[IDX_DMA] = dma_req;
        int_req[IDX_CPU] = 1'b1;
    end

    prio_pick #(.N(NUM_INT)) u_pick (
        .req    (int_req),
        .onehot (int_pick)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_OWN: begin
                if (cycle_done) begin
                    if (ext_want) regs_d.state = ST_PARK;
                    else          regs_d.owner = int_pick;
                end
            end
            ST_PARK:  regs_d.state = ST_FLOAT;
            ST_FLOAT: regs_d.state = ST_LENT;
            ST_LENT: begin
                if (!ext_want) begin
                    regs_d.state = ST_OWN;
                    regs_d.owner = int_pick;
                end else if (refresh_req) begin
                    regs_d.state = ST_RECLAIM;
                end
            end
            ST_RECLAIM: begin
                if (!ext_want) begin
                    regs_d.state = ST_OWN;
                    regs_d.owner = NUM_INT'(1) << IDX_REF;
                end
            end
            default: begin
                regs_d.state = ST_OWN;
                regs_d.owner = CPU_ONLY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_OWN;
            regs_q.owner <= CPU_ONLY;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign drive_on    = (regs_q.state == ST_OWN) || (regs_q.state == ST_PARK);
    assign addr_oe     = drive_on;
    assign data_oe     = drive_on;
    assign strobe_oe   = drive_on;
    assign strobe_park = (regs_q.state == ST_PARK);
    assign ext_ack_n   = !(regs_q.state == ST_LENT);
    assign gnt_refresh = (regs_q.state == ST_OWN) && regs_q.owner[IDX_REF];
    assign gnt_dma     = (regs_q.state == ST_OWN) && regs_q.owner[IDX_DMA];
    assign gnt_cpu     = (regs_q.state == ST_OWN) && regs_q.owner[IDX_CPU];
    assign gnt_vec     = {gnt_refresh, gnt_dma, gnt_cpu};

    AST_FLOAT_WHEN_LENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_ack_n |-> (!addr_oe && !data_oe && !strobe_oe)); // R5

    AST_GNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vec) && (ext_ack_n || gnt_vec == 3'b000)); // R3

    AST_PARK_BEFORE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_oe) |-> $past(strobe_park)); // R4

    AST_ACK_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_ack_n) |-> $past(!addr_oe)); // R4

    AST_DRIVE_AFTER_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_oe) |-> $past(req_n_sync)); // R8

    AST_ACK_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_ack_n) |-> (addr_oe || $past(refresh_req))); // R8

    AST_GNT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ((|$past(gnt_vec)) && (gnt_vec != $past(gnt_vec))) |-> $past(cycle_done)); // R7

endmodule

// File: tb/tb_bus_release_arb.sv
module tb_bus_release_arb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req_n = 1'b1;
    logic refresh_req = 1'b0;
    logic dma_req = 1'b0;
    logic cycle_done = 1'b0;
    logic ext_ack_n, gnt_refresh, gnt_dma, gnt_cpu;
    logic addr_oe, data_oe, strobe_oe, strobe_park;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bus_release_arb dut (
        .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n),
        .refresh_req(refresh_req), .dma_req(dma_req), .cycle_done(cycle_done),
        .ext_ack_n(ext_ack_n), .gnt_refresh(gnt_refresh), .gnt_dma(gnt_dma),
        .gnt_cpu(gnt_cpu), .addr_oe(addr_oe), .data_oe(data_oe),
        .strobe_oe(strobe_oe), .strobe_park(strobe_park)
    );

    // {ext_req_n, refresh, dma, cycle_done} | ack_n | {gnt_ref,gnt_dma,gnt_cpu} | oe | park
    localparam int NV = 25;
    localparam logic [9:0] VEC [NV] = '{
        10'b1010_1_001_10, // R7 no boundary, CPU holds
        10'b1011_1_010_10, // R2 DMA over CPU
        10'b1110_1_010_10, // R7 refresh waits for boundary
        10'b1111_1_100_10, // R2 refresh over DMA
        10'b1011_1_010_10, // R2
        10'b0010_1_010_10, // R7 sync stage 1
        10'b0010_1_010_10, // R7 sync stage 2
        10'b0010_1_010_10, // R7 mid-cycle, DMA burst keeps bus
        10'b0011_1_000_11, // R6 R4 park
        10'b0010_1_000_00, // R4 float, ack high
        10'b0010_0_000_00, // R4 R5 ack low
        10'b0000_0_000_00, // R5
        10'b0100_1_000_00, // R8 ack withdrawn
        10'b0100_1_000_00, // R8 still floated
        10'b1100_1_000_00, // R8 waiting on sync
        10'b1100_1_000_00, // R8
        10'b0100_1_100_10, // R8 refresh granted
        10'b0100_1_100_10, // R10
        10'b0001_1_000_11, // R10 park again
        10'b0000_1_000_00, // R10 float
        10'b0000_0_000_00, // R10 R3 lent
        10'b1010_0_000_00, // R9
        10'b1010_0_000_00, // R9
        10'b1010_1_010_10, // R9 return to DMA
        10'b1001_1_001_10  // R2 CPU default
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] outs();
        return {ext_ack_n, gnt_refresh, gnt_dma, gnt_cpu, addr_oe, strobe_park};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #5;
        check("R1 outputs in reset", {26'd0, outs()}, {26'd0, 6'b1_001_10});
        check("R1 oe pins in reset", {29'd0, addr_oe, data_oe, strobe_oe}, 32'd7);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #5;
        check("R1 after reset", {26'd0, outs()}, {26'd0, 6'b1_001_10});

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {ext_req_n, refresh_req, dma_req, cycle_done} = VEC[i][9:6];
            @(posedge clk); #5;
            check($sformatf("vector %0d", i), {26'd0, outs()},
                  {26'd0, VEC[i][5:2], VEC[i][1], VEC[i][0]});
            if (!ext_ack_n)
                check("R5 pins floated", {29'd0, addr_oe, data_oe, strobe_oe}, 32'd0);
            check("R3 one grant", 32'($countones({gnt_refresh, gnt_dma, gnt_cpu}) <= 1), 32'd1);
        end

        // R8 refresh and request drop arriving together while lent
        @(negedge clk);
        {ext_req_n, refresh_req, dma_req, cycle_done} = 4'b0001;
        repeat (5) @(posedge clk);
        #5;
        check("R4 lent after five edges", {31'd0, ext_ack_n}, 32'd0);
        @(negedge clk);
        {ext_req_n, refresh_req, dma_req, cycle_done} = 4'b1100;
        @(posedge clk); #5;
        check("R8 ack raised, floated", {30'd0, ext_ack_n, addr_oe}, 32'b10);
        repeat (2) @(posedge clk);
        #5;
        check("R8 refresh owns bus", {26'd0, outs()}, {26'd0, 6'b1_100_10});

        // R1 reset while lent
        @(negedge clk);
        {ext_req_n, refresh_req, dma_req, cycle_done} = 4'b0001;
        repeat (5) @(posedge clk);
        #5;
        check("R5 lent before reset", {26'd0, outs()}, {26'd0, 6'b0_000_00});
        rst_n = 1'b0;
        #1;
        check("R1 async reset while lent", {26'd0, outs()}, {26'd0, 6'b1_001_10});
        @(negedge clk) rst_n = 1'b1;
        ext_req_n = 1'b1;

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule